// File: doc/BRIEF.md
# Programmable Raster Panel Timing Generator

This block produces the scan timing for a raster LCD panel. A horizontal counter advances once per pixel clock and a vertical counter advances once per line. From these two counts it derives horizontal sync, vertical sync, a data-enable window, the pixel coordinates inside that window, and four auxiliary control strobes. Every window is set in software through a small register write port. Each window register packs a start count in its upper half and an end count in its lower half.

Register writes go to a staging bank. While the generator is idle the staging bank is copied into the working bank on every cycle. While it runs, the copy happens only at the frame boundary, so a frame never mixes two timings. A command register starts the scan. The same register can also stop the scan, either gracefully at the end of the current frame or at once. A serial option covers panels that take one colour channel per clock. In that mode three clocks make one pixel, and a channel index output tells which channel is on the bus.

Top module: `lcd_raster_timer`

## Requirements
- R1: After reset, running, hsync, vsync, de, pix_x, pix_y and chan are all 0. Each aux output sits at its inactive level, which is 0 for all four with the reset polarities.
- R2: Writing address 0 with bit 0 set while idle starts the scan. On the next cycle the counters are at h=0 and v=0. Address 2 holds the clocks per line in bits 31:16 and the lines per frame in bits 15:0. h wraps to 0 after total-1. v advances once per line and wraps after lines-1.
- R3: Address 3 bits 15:0 give the horizontal sync width. While running, hsync is high exactly when h < width.
- R4: Address 4 bits 15:0 give the vertical sync width. While running, vsync is high exactly when v < width.
- R5: Address 5 holds the horizontal active start in bits 31:16 and its end in bits 15:0. Address 6 holds the vertical start and end in the same layout. de is high exactly when start <= h < end and start <= v < end in both axes.
- R6: With the serial option off (address 1 bit 0 = 0), pix_x = h - horizontal start and pix_y = v - vertical start while de is high. Both are 0 while de is low.
- R7: With address 1 bit 0 = 1, pix_x = floor((h - horizontal start)/3) and chan = (h - horizontal start) mod 3 while de is high. chan is 0 otherwise.
- R8: Aux strobe i is set by address 7+i, with start in bits 31:16 and end in bits 15:0. The strobe is active when start <= h < end. When end exceeds the clocks per line, it is also active while h < end - total, which carries the strobe into the next line.
- R9: Address 1 bits 4:1 set the polarity of aux0..aux3. A 1 (the reset value) means active-high and a 0 means active-low. While idle, each aux output holds its inactive level.
- R10: A write to addresses 1..10 while running takes effect on the first cycle of the next frame. A write while idle takes effect one cycle after it lands.
- R11: Address 0 bit 1 requests a graceful stop. running stays high for the rest of the current frame and drops on the cycle after the frame's last clock.
- R12: Address 0 bit 2 halts the scan. On the next cycle running is 0, the counters are back at 0 and all outputs are idle. A halt overrides both start and graceful stop.
- R13: A start command received while running has no effect, and the count continues without a break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 32 | Register write data |
| running | output | 1 | Scan in progress |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Active-area data enable |
| pix_x | output | 16 | Pixel column inside the active area |
| pix_y | output | 16 | Pixel row inside the active area |
| chan | output | 2 | Colour channel index in serial mode |
| aux | output | 4 | Auxiliary panel-control strobes |

## Verification
The hardest situations to reach from the ports are a register write landing in the middle of a running frame and a stop request arriving part-way through a frame. In both cases the effect must wait for the frame boundary, so a frame that runs on stale settings looks plausible unless the exact switch cycle is checked. The stimulus therefore writes a new sync width and issues a repeated start part-way through a directed frame, then requests a graceful stop in the next frame. A reference model in the bench keeps its own pending and working register copies, so every output is compared cycle by cycle across the boundary. Random configurations with strobe ends beyond the line total, together with serial mode and a halt in mid-frame, cover the wrap-around strobe and the channel phase.

// File: rtl/lcd_rt_pkg.sv
package lcd_rt_pkg;
   localparam int ADDR_W = 4;

   localparam logic [ADDR_W-1:0] RA_CMD   = 4'd0;
   localparam logic [ADDR_W-1:0] RA_CFG   = 4'd1;
   localparam logic [ADDR_W-1:0] RA_TOTAL = 4'd2;
   localparam logic [ADDR_W-1:0] RA_HSW   = 4'd3;
   localparam logic [ADDR_W-1:0] RA_VSW   = 4'd4;
   localparam logic [ADDR_W-1:0] RA_HACT  = 4'd5;
   localparam logic [ADDR_W-1:0] RA_VACT  = 4'd6;
   localparam int                RA_AUX0  = 7;

   // command register bit positions
   localparam int CMD_START = 0;
   localparam int CMD_STOP  = 1;
   localparam int CMD_HALT  = 2;
endpackage

// File: rtl/lcd_rt_regs.sv
module lcd_rt_regs import lcd_rt_pkg::*; #(
   parameter int CW        = 16,
   parameter int NAUX      = 4,
   parameter bit SERIAL_EN = 1'b1,
   parameter int DEF_HTOT  = 16,
   parameter int DEF_VTOT  = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [ADDR_W-1:0]         wr_addr,
   input  logic [2*CW-1:0]           wr_data,
   input  logic                      load,
   output logic [CW-1:0]             htot,
   output logic [CW-1:0]             vtot,
   output logic [CW-1:0]             hsw,
   output logic [CW-1:0]             vsw,
   output logic [CW-1:0]             hs,
   output logic [CW-1:0]             he,
   output logic [CW-1:0]             vs,
   output logic [CW-1:0]             ve,
   output logic [NAUX-1:0][CW-1:0]   aux_s,
   output logic [NAUX-1:0][CW-1:0]   aux_e,
   output logic                      serial,
   output logic [NAUX-1:0]           pol
);
   localparam int DW = 2*CW;

   logic [CW-1:0]   st_htot, st_vtot, st_hsw, st_vsw, st_hs, st_he, st_vs, st_ve;
   logic [NAUX-1:0] st_pol;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_htot <= CW'(DEF_HTOT);
         st_vtot <= CW'(DEF_VTOT);
         st_hsw  <= '0;
         st_vsw  <= '0;
         st_hs   <= '0;
         st_he   <= '0;
         st_vs   <= '0;
         st_ve   <= '0;
         st_pol  <= '1;
      end else if (wr_en) begin
         case (wr_addr)
            RA_CFG:   st_pol <= wr_data[NAUX:1];
            RA_TOTAL: begin st_htot <= wr_data[DW-1:CW]; st_vtot <= wr_data[CW-1:0]; end
            RA_HSW:   st_hsw <= wr_data[CW-1:0];
            RA_VSW:   st_vsw <= wr_data[CW-1:0];
            RA_HACT:  begin st_hs <= wr_data[DW-1:CW]; st_he <= wr_data[CW-1:0]; end
            RA_VACT:  begin st_vs <= wr_data[DW-1:CW]; st_ve <= wr_data[CW-1:0]; end
            default:  ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         htot <= CW'(DEF_HTOT);
         vtot <= CW'(DEF_VTOT);
         hsw  <= '0;
         vsw  <= '0;
         hs   <= '0;
         he   <= '0;
         vs   <= '0;
         ve   <= '0;
         pol  <= '1;
      end else if (load) begin
         htot <= st_htot;
         vtot <= st_vtot;
         hsw  <= st_hsw;
         vsw  <= st_vsw;
         hs   <= st_hs;
         he   <= st_he;
         vs   <= st_vs;
         ve   <= st_ve;
         pol  <= st_pol;
      end
   end

   generate
      if (SERIAL_EN) begin : g_serial
         logic st_ser, ac_ser;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          st_ser <= 1'b0;
            else if (wr_en && wr_addr == RA_CFG) st_ser <= wr_data[0];
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    ac_ser <= 1'b0;
            else if (load) ac_ser <= st_ser;
         end
         assign serial = ac_ser;
      end else begin : g_parallel
         assign serial = 1'b0;
      end
   endgenerate

   for (genvar i = 0; i < NAUX; i++) begin : g_aux
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(RA_AUX0 + i);
      logic [CW-1:0] st_s, st_e, ac_s, ac_e;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_s <= '0;
            st_e <= '0;
         end else if (wr_en && wr_addr == MY_ADDR) begin
            st_s <= wr_data[DW-1:CW];
            st_e <= wr_data[CW-1:0];
         end
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ac_s <= '0;
            ac_e <= '0;
         end else if (load) begin
            ac_s <= st_s;
            ac_e <= st_e;
         end
      end
      assign aux_s[i] = ac_s;
      assign aux_e[i] = ac_e;
   end
endmodule

// File: rtl/lcd_rt_counter.sv
module lcd_rt_counter #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_start,
   input  logic          cmd_stop,
   input  logic          cmd_halt,
   input  logic [CW-1:0] htot,
   input  logic [CW-1:0] vtot,
   output logic          running,
   output logic [CW-1:0] h_cnt,
   output logic [CW-1:0] v_cnt,
   output logic          frame_wrap,
   output logic          load
);
   logic stop_pend;
   logic h_last, v_last;

   assign h_last     = (h_cnt == htot - 1'b1);
   assign v_last     = (v_cnt == vtot - 1'b1);
   assign frame_wrap = running && h_last && v_last;
   assign load       = !running || frame_wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running   <= 1'b0;
         stop_pend <= 1'b0;
         h_cnt     <= '0;
         v_cnt     <= '0;
      end else if (cmd_halt) begin
         running   <= 1'b0;
         stop_pend <= 1'b0;
         h_cnt     <= '0;
         v_cnt     <= '0;
      end else if (!running) begin
         stop_pend <= 1'b0;
         h_cnt     <= '0;
         v_cnt     <= '0;
         if (cmd_start) running <= 1'b1;
      end else if (frame_wrap && stop_pend) begin
         running   <= 1'b0;
         stop_pend <= 1'b0;
         h_cnt     <= '0;
         v_cnt     <= '0;
      end else begin
         if (cmd_stop) stop_pend <= 1'b1;
         if (h_last) begin
            h_cnt <= '0;
            v_cnt <= v_last ? '0 : v_cnt + 1'b1;
         end else begin
            h_cnt <= h_cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/lcd_rt_window.sv
module lcd_rt_window #(
   parameter int CW = 16
) (
   input  logic [CW-1:0] pos,
   input  logic [CW-1:0] first,
   input  logic [CW-1:0] last,
   input  logic [CW-1:0] total,
   output logic          on
);
   logic [CW-1:0] spill;
   logic          in_fwd, in_spill;

   assign spill    = last - total;
   assign in_fwd   = (pos >= first) && (pos < last);
   assign in_spill = (last > total) && (pos < spill);
   assign on       = in_fwd || in_spill;
endmodule

// File: rtl/lcd_rt_pixpos.sv
module lcd_rt_pixpos #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          de,
   input  logic          line_start,
   input  logic          serial,
   output logic [CW-1:0] x,
   output logic [1:0]    chan
);
   logic [CW-1:0] px_q, cur_x;
   logic [1:0]    ch_q, cur_c;

   assign cur_x = line_start ? '0 : px_q;
   assign cur_c = line_start ? 2'd0 : ch_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         px_q <= '0;
         ch_q <= '0;
      end else if (de) begin
         if (serial && cur_c != 2'd2) begin
            ch_q <= cur_c + 2'd1;
            px_q <= cur_x;
         end else begin
            ch_q <= 2'd0;
            px_q <= cur_x + 1'b1;
         end
      end
   end

   assign x    = de ? cur_x : '0;
   assign chan = de ? cur_c : 2'd0;
endmodule

// File: rtl/lcd_raster_timer.sv
module lcd_raster_timer import lcd_rt_pkg::*; #(
   parameter int CW        = 16,
   parameter int NAUX      = 4,
   parameter bit SERIAL_EN = 1'b1,
   parameter int DEF_HTOT  = 16,
   parameter int DEF_VTOT  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [2*CW-1:0]   wr_data,
   output logic              running,
   output logic              hsync,
   output logic              vsync,
   output logic              de,
   output logic [CW-1:0]     pix_x,
   output logic [CW-1:0]     pix_y,
   output logic [1:0]        chan,
   output logic [NAUX-1:0]   aux
);
   generate
      if (CW < 4) begin : g_bad_cw
         $error("lcd_raster_timer: CW must be at least 4");
      end
      if (NAUX < 1 || NAUX > 4) begin : g_bad_naux
         $error("lcd_raster_timer: NAUX must lie in 1..4");
      end
      if (DEF_HTOT < 1 || DEF_VTOT < 1) begin : g_bad_def
         $error("lcd_raster_timer: default totals must be nonzero");
      end
   endgenerate

   logic                    cmd_hit, halt, start, stop;
   logic                    frame_wrap, load;
   logic [CW-1:0]           h_cnt, v_cnt;
   logic [CW-1:0]           htot, vtot, hsw, vsw, hs, he, vs, ve;
   logic [NAUX-1:0][CW-1:0] aux_s, aux_e;
   logic [NAUX-1:0]         pol, aux_on;
   logic                    serial;
   logic                    h_win, v_win, line_start;

   assign cmd_hit = wr_en && (wr_addr == RA_CMD);
   assign halt    = cmd_hit && wr_data[CMD_HALT];
   assign start   = cmd_hit && wr_data[CMD_START];
   assign stop    = cmd_hit && wr_data[CMD_STOP];

   lcd_rt_regs #(
      .CW(CW), .NAUX(NAUX), .SERIAL_EN(SERIAL_EN),
      .DEF_HTOT(DEF_HTOT), .DEF_VTOT(DEF_VTOT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .load(load),
      .htot(htot), .vtot(vtot), .hsw(hsw), .vsw(vsw),
      .hs(hs), .he(he), .vs(vs), .ve(ve),
      .aux_s(aux_s), .aux_e(aux_e), .serial(serial), .pol(pol)
   );

   lcd_rt_counter #(.CW(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .cmd_start(start), .cmd_stop(stop), .cmd_halt(halt),
      .htot(htot), .vtot(vtot),
      .running(running), .h_cnt(h_cnt), .v_cnt(v_cnt),
      .frame_wrap(frame_wrap), .load(load)
   );

   assign h_win      = (h_cnt >= hs) && (h_cnt < he);
   assign v_win      = (v_cnt >= vs) && (v_cnt < ve);
   assign de         = running && h_win && v_win;
   assign hsync      = running && (h_cnt < hsw);
   assign vsync      = running && (v_cnt < vsw);
   assign line_start = (h_cnt == hs);
   assign pix_y      = de ? (v_cnt - vs) : '0;

   lcd_rt_pixpos #(.CW(CW)) u_pix (
      .clk(clk), .rst_n(rst_n), .de(de), .line_start(line_start),
      .serial(serial), .x(pix_x), .chan(chan)
   );

   for (genvar i = 0; i < NAUX; i++) begin : g_strobe
      lcd_rt_window #(.CW(CW)) u_win (
         .pos(h_cnt), .first(aux_s[i]), .last(aux_e[i]),
         .total(htot), .on(aux_on[i])
      );
      assign aux[i] = running ? (pol[i] ? aux_on[i] : !aux_on[i]) : !pol[i];
   end
endmodule

// File: rtl/lcd_rt_checker.sv
module lcd_rt_checker #(
   parameter int CW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          running,
   input logic          halt,
   input logic          frame_wrap,
   input logic [CW-1:0] h_cnt,
   input logic [CW-1:0] htot,
   input logic [CW-1:0] hs,
   input logic [CW-1:0] he,
   input logic          de,
   input logic          hsync,
   input logic          vsync,
   input logic [1:0]    chan,
   input logic          serial
);
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> (!de && !hsync && !vsync));

   a_r2_h_step: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !halt && h_cnt != htot - 1'b1) |=> (h_cnt == CW'($past(h_cnt) + 1'b1)));

   a_r5_de_inside: assert property (@(posedge clk) disable iff (!rst_n)
      de |-> (h_cnt >= hs && h_cnt < he));

   a_r7_chan_range: assert property (@(posedge clk) disable iff (!rst_n)
      (chan != 2'd3) && (!serial -> chan == 2'd0));

   a_r10_frame_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !frame_wrap) |=> ($stable(htot) && $stable(hs) && $stable(he)));

   a_r11_stop_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(running) |-> ($past(frame_wrap) || $past(halt)));

   a_r12_halt_now: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> (!running && h_cnt == '0));
endmodule

bind lcd_raster_timer lcd_rt_checker #(.CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .running(running), .halt(halt),
   .frame_wrap(frame_wrap), .h_cnt(h_cnt), .htot(htot), .hs(hs), .he(he),
   .de(de), .hsync(hsync), .vsync(vsync), .chan(chan), .serial(serial)
);

// File: tb/sim_lcd_raster_timer.sv
module sim_lcd_raster_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        running, hsync, vsync, de;
   logic [15:0] pix_x, pix_y;
   logic [1:0]  chan;
   logic [3:0]  aux;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   string scen = "";

   // reference model state
   logic [31:0] cur [1:10];
   logic [31:0] pend[1:10];
   bit mrun, msp;
   int mh, mv;

   always #10 clk = ~clk;

   lcd_raster_timer u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .running(running), .hsync(hsync), .vsync(vsync),
      .de(de), .pix_x(pix_x), .pix_y(pix_y), .chan(chan), .aux(aux)
   );

   task automatic chk(input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", scen, what, act, exp);
      end
   endtask

   function automatic int hi(input logic [31:0] w); return int'(w[31:16]); endfunction
   function automatic int lo(input logic [31:0] w); return int'(w[15:0]); endfunction

   task automatic check_outputs();
      int htot, hs, he, vs, ve, dx, s, e;
      bit e_de, on, p;
      int e_aux;
      htot = hi(cur[2]);
      hs = hi(cur[5]); he = lo(cur[5]);
      vs = hi(cur[6]); ve = lo(cur[6]);
      e_de = mrun && mh >= hs && mh < he && mv >= vs && mv < ve;
      dx = mh - hs;
      chk("R2 R11 R12 R13 running", int'(running), int'(mrun));
      chk("R3 hsync", int'(hsync), int'(mrun && mh < lo(cur[3])));
      chk("R4 vsync", int'(vsync), int'(mrun && mv < lo(cur[4])));
      chk("R5 de", int'(de), int'(e_de));
      if (cur[1][0]) begin
         chk("R7 pix_x", int'(pix_x), e_de ? dx / 3 : 0);
         chk("R7 chan", int'(chan), e_de ? dx % 3 : 0);
      end else begin
         chk("R6 pix_x", int'(pix_x), e_de ? dx : 0);
         chk("R6 chan", int'(chan), 0);
      end
      chk("R6 pix_y", int'(pix_y), e_de ? mv - vs : 0);
      e_aux = 0;
      for (int i = 0; i < 4; i++) begin
         s = hi(cur[7+i]); e = lo(cur[7+i]);
         on = (mh >= s && mh < e) || (e > htot && mh < e - htot);
         p = cur[1][i+1];
         if (mrun) e_aux |= int'(p ? on : !on) << i;
         else      e_aux |= int'(!p) << i;
      end
      chk("R8 R9 aux", int'(aux), e_aux);
   endtask

   task automatic model_edge(input bit we, input logic [3:0] a, input logic [31:0] d);
      bit q, st, sp, wrap, ld;
      int htot, vtot;
      q  = we && a == 0 && d[2];
      st = we && a == 0 && d[0];
      sp = we && a == 0 && d[1];
      htot = hi(cur[2]); vtot = lo(cur[2]);
      wrap = mrun && mh == htot - 1 && mv == vtot - 1;
      ld = !mrun || wrap;
      if (q) begin
         mrun = 0; msp = 0; mh = 0; mv = 0;
      end else if (!mrun) begin
         msp = 0; mh = 0; mv = 0;
         if (st) mrun = 1;
      end else if (wrap && msp) begin
         mrun = 0; msp = 0; mh = 0; mv = 0;
      end else begin
         if (sp) msp = 1;
         if (mh == htot - 1) begin
            mh = 0;
            mv = (mv == vtot - 1) ? 0 : mv + 1;
         end else mh++;
      end
      if (ld) for (int k = 1; k <= 10; k++) cur[k] = pend[k];
      if (we && a >= 1 && a <= 10) pend[a] = d;
   endtask

   // called at a falling edge: check, drive, cross the rising edge, update model
   task automatic tick(input bit we, input logic [3:0] a, input logic [31:0] d);
      check_outputs();
      wr_en = we; wr_addr = a; wr_data = d;
      @(posedge clk);
      model_edge(we, a, d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) tick(1'b0, 4'd0, 32'd0);
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      tick(1'b1, a, d);
   endtask

   function automatic logic [31:0] pk(input int h, input int l);
      return {h[15:0], l[15:0]};
   endfunction

   initial begin
      int ht, vt, hsw, vsw, hs, he, vs, ve, s;
      cur[1] = 32'h1E; pend[1] = 32'h1E;
      cur[2] = pk(16, 4); pend[2] = pk(16, 4);
      for (int k = 3; k <= 10; k++) begin cur[k] = '0; pend[k] = '0; end
      mrun = 0; msp = 0; mh = 0; mv = 0;
      void'($urandom(32'd4711));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      scen = "R1";
      idle(3);

      // directed parallel frame with a spilling aux strobe and an active-low one
      scen = "A";
      wr(4'd1, 32'h0E);
      wr(4'd2, pk(20, 8));
      wr(4'd3, 32'd3);
      wr(4'd4, 32'd2);
      wr(4'd5, pk(5, 17));
      wr(4'd6, pk(3, 7));
      wr(4'd7, pk(2, 6));
      wr(4'd8, pk(15, 24));
      wr(4'd9, pk(0, 1));
      wr(4'd10, pk(10, 12));
      idle(2);
      wr(4'd0, 32'd1);
      idle(60);
      scen = "R13";
      wr(4'd0, 32'd1);
      idle(20);
      scen = "R10";
      wr(4'd3, 32'd5);
      wr(4'd5, pk(4, 16));
      idle(120);
      scen = "R11";
      wr(4'd0, 32'd2);
      idle(140);
      chk("R11 stopped after frame end", int'(running), 0);

      // serial mode with mixed polarities
      scen = "R7";
      wr(4'd1, 32'h15);
      wr(4'd2, pk(30, 5));
      wr(4'd3, 32'd2);
      wr(4'd4, 32'd1);
      wr(4'd5, pk(4, 28));
      wr(4'd6, pk(1, 5));
      wr(4'd7, pk(0, 35));
      wr(4'd8, pk(29, 30));
      wr(4'd9, pk(3, 9));
      wr(4'd10, pk(12, 13));
      idle(2);
      wr(4'd0, 32'd1);
      idle(200);
      scen = "R12";
      wr(4'd0, 32'd6);
      idle(10);

      // random configurations
      for (int r = 0; r < 8; r++) begin
         scen = $sformatf("rand%0d", r);
         ht  = 12 + int'($urandom_range(0, 20));
         vt  = 4 + int'($urandom_range(0, 5));
         hsw = 1 + int'($urandom_range(0, 2));
         vsw = 1 + int'($urandom_range(0, 1));
         hs  = hsw + int'($urandom_range(0, 2));
         he  = hs + 1 + int'($urandom_range(0, ht - hs - 1));
         vs  = vsw + int'($urandom_range(0, 1));
         ve  = vs + 1 + int'($urandom_range(0, vt - vs - 1));
         wr(4'd1, {27'd0, 4'($urandom_range(0, 15)), 1'($urandom_range(0, 1))});
         wr(4'd2, pk(ht, vt));
         wr(4'd3, hsw);
         wr(4'd4, vsw);
         wr(4'd5, pk(hs, he));
         wr(4'd6, pk(vs, ve));
         for (int i = 0; i < 4; i++) begin
            s = int'($urandom_range(0, ht - 1));
            wr(4'(7 + i), pk(s, s + 1 + int'($urandom_range(0, ht - 1))));
         end
         idle(2);
         wr(4'd0, 32'd1);
         idle(ht * vt + int'($urandom_range(0, 40)));
         wr(4'd0, 32'd4);
         idle(4);
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog R2: actual %0d expected %0d", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule